// File: doc/BRIEF.md
# Refresh-Monitored Isolation Channel Logic

This block is a synthesizable digital model of the data path across a galvanic isolation link. Each channel has a sending half and a receiving half. A single-bit pulse link joins them. The sending half synchronises its logic input and removes pulses shorter than a programmable minimum width. It then sends the filtered level as a pulse code. It sends a code whenever the level changes. While the input is static, it repeats the current code at a fixed refresh interval.

The receiving half measures each pulse and decodes the level from it. A watchdog counts the cycles since the last good code. If that count reaches the failsafe timeout, the output is forced high. An unpowered or silent sender therefore reads as logic high on the far side.

The wrapper holds four channels. Three carry data from side A to side B, and one carries data from side B to side A. Each side has its own output enable. A low enable releases the pad drivers on that side.

Top module: `iso_quad_link`

## Requirements
- R1: A change of the input level lasting fewer than `MIN_WIDTH_CYC` clock cycles never reaches the output. A change lasting `MIN_WIDTH_CYC` cycles or longer is passed on.
- R2: A stable input level, high or low, appears on the enabled output of the far side within `MIN_WIDTH_CYC + 12` cycles.
- R3: Link code: a high-level code is a 1-cycle link pulse and a low-level code is a 2-cycle link pulse. There is at least one idle cycle between pulses. Pulses of 3 or more cycles are discarded. The receiver output changes only on the cycle after a correctly decoded code, or when the failsafe timeout expires.
- R4: While the sender is powered, it resends the current level every `REFRESH_CYC` idle cycles, even with a static input. `REFRESH_CYC` must be below `FAILSAFE_CYC`, so a static level stays on the output for as long as it is held.
- R5: If no valid code arrives for `FAILSAFE_CYC` cycles, the receiver output goes to 1. Before that time it keeps the last decoded level.
- R6: After reset, every receiver output is 1 until the first valid code arrives.
- R7: When a side's enable is 0, its output-enable pins are 0 in the same cycle, whatever the input or link state. When the enable is 1, they are 1 and the data pins carry the recovered level.
- R8: When a side's sending power input is 0, that side sends no codes. The channels it feeds read 1 on the far side once the failsafe timeout has passed.
- R9: `fwd_in` feeds `fwd_out`, which is gated by `en_b` and powered by `pwr_a`. `rev_in` feeds `rev_out`, which is gated by `en_a` and powered by `pwr_b`. Bit n of each input bus maps to bit n of its output bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both halves |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_a | input | 1 | Side A sending power present (1 = powered) |
| pwr_b | input | 1 | Side B sending power present (1 = powered) |
| en_a | input | 1 | Output enable for side-A outputs (`rev_*`) |
| en_b | input | 1 | Output enable for side-B outputs (`fwd_*`) |
| fwd_in | input | NUM_FWD | Side-A logic inputs, sent to side B |
| rev_in | input | NUM_REV | Side-B logic inputs, sent to side A |
| fwd_out | output | NUM_FWD | Recovered levels on side B |
| fwd_oe | output | NUM_FWD | Side-B pad drive enables (0 = high impedance) |
| rev_out | output | NUM_REV | Recovered levels on side A |
| rev_oe | output | NUM_REV | Side-A pad drive enables (0 = high impedance) |

## Verification
The assertions check on every cycle that:
- no link pulse lasts longer than two cycles;
- the refresh counter stays below its limit;
- a decoded code sets the receiver level on the next cycle;
- the receiver level changes only through a code or a timeout;
- the filtered level flips only after a full minimum-width run.

Some behaviours can only be shown by the bench scenarios. These are:
- the end-to-end latency of both polarities;
- rejection of near-threshold glitches at the pins;
- the failsafe after a lost sender, and the boundary before it;
- recovery through refresh traffic;
- the reset-time high output.

// File: rtl/iso_link_pkg.sv
package iso_link_pkg;

    typedef enum logic [1:0] {
        TX_WAIT,
        TX_MARK1,
        TX_MARK2,
        TX_SPACE
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_ONE,
        RX_TWO,
        RX_LONG
    } rx_state_e;

endpackage

// File: rtl/iso_pulse_filter.sv
module iso_pulse_filter #(
    parameter int MIN_WIDTH_CYC = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl
);
    localparam int CW = $clog2(MIN_WIDTH_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;
    logic          lvl_q;
    logic          smp;

    assign smp = sync_q[1];
    assign lvl = lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            run_q  <= '0;
            lvl_q  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            if (smp == lvl_q) begin
                run_q <= '0;
            end else if (run_q == CW'(MIN_WIDTH_CYC - 1)) begin
                lvl_q <= smp;
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // R1
    filt_min_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q != $past(lvl_q)) |-> ($past(run_q) == CW'(MIN_WIDTH_CYC - 1)));

endmodule

// File: rtl/iso_tx_encoder.sv
module iso_tx_encoder
    import iso_link_pkg::*;
#(
    parameter int REFRESH_CYC = 750
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr,
    input  logic lvl,
    output logic link
);
    localparam int RW = $clog2(REFRESH_CYC + 1);

    tx_state_e     state_q, state_d;
    logic          sent_q;
    logic [RW-1:0] refr_q;
    logic          start;

    assign start = pwr && ((lvl != sent_q) || (refr_q == RW'(REFRESH_CYC - 1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_WAIT;
            sent_q  <= 1'b0;
            refr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == TX_WAIT && start) sent_q <= lvl;
            if (state_q != TX_WAIT || !pwr || start) refr_q <= '0;
            else                                     refr_q <= refr_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        link    = 1'b0;
        unique case (state_q)
            TX_WAIT:  if (start) state_d = TX_MARK1;
            TX_MARK1: begin
                link    = 1'b1;
                state_d = sent_q ? TX_SPACE : TX_MARK2;
            end
            TX_MARK2: begin
                link    = 1'b1;
                state_d = TX_SPACE;
            end
            TX_SPACE: state_d = TX_WAIT;
            default:  state_d = TX_WAIT;
        endcase
    end

    // R3
    tx_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link && $past(link)) |=> !link);

    // R4
    tx_refresh_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_WAIT && pwr) |-> (refr_q < RW'(REFRESH_CYC)));

endmodule

// File: rtl/iso_rx_decoder.sv
module iso_rx_decoder
    import iso_link_pkg::*;
#(
    parameter int FAILSAFE_CYC = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link,
    output logic level
);
    localparam int WW = $clog2(FAILSAFE_CYC + 1);

    rx_state_e     state_q, state_d;
    logic          code_ok, code_hi;
    logic [WW-1:0] wd_q;
    logic          data_q;
    logic          expired;

    assign expired = (wd_q == WW'(FAILSAFE_CYC - 1));
    assign level   = data_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        code_ok = 1'b0;
        code_hi = 1'b0;
        unique case (state_q)
            RX_IDLE: if (link) state_d = RX_ONE;
            RX_ONE:  if (link) state_d = RX_TWO;
                     else begin code_ok = 1'b1; code_hi = 1'b1; state_d = RX_IDLE; end
            RX_TWO:  if (link) state_d = RX_LONG;
                     else begin code_ok = 1'b1; state_d = RX_IDLE; end
            RX_LONG: if (!link) state_d = RX_IDLE;
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= 1'b1;
            wd_q   <= '0;
        end else if (code_ok) begin
            data_q <= code_hi;
            wd_q   <= '0;
        end else if (expired) begin
            data_q <= 1'b1;
        end else begin
            wd_q   <= wd_q + 1'b1;
        end
    end

    // R3
    rx_code_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_ok |=> (data_q == $past(code_hi)));

    // R3
    rx_update_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_q != $past(data_q)) |-> ($past(code_ok) || $past(expired)));

    // R5
    rx_failsafe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!code_ok && expired) |=> data_q);

endmodule

// File: rtl/iso_lane.sv
module iso_lane #(
    parameter int MIN_WIDTH_CYC = 200,
    parameter int REFRESH_CYC   = 750,
    parameter int FAILSAFE_CYC  = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_pwr,
    input  logic din,
    input  logic en,
    output logic dout,
    output logic doe
);
    logic lvl;
    logic link;

    iso_pulse_filter #(.MIN_WIDTH_CYC(MIN_WIDTH_CYC)) u_filt (
        .clk(clk), .rst_n(rst_n), .din(din), .lvl(lvl)
    );

    iso_tx_encoder #(.REFRESH_CYC(REFRESH_CYC)) u_tx (
        .clk(clk), .rst_n(rst_n), .pwr(src_pwr), .lvl(lvl), .link(link)
    );

    iso_rx_decoder #(.FAILSAFE_CYC(FAILSAFE_CYC)) u_rx (
        .clk(clk), .rst_n(rst_n), .link(link), .level(dout)
    );

    assign doe = en;

endmodule

// File: rtl/iso_quad_link.sv
module iso_quad_link #(
    parameter int NUM_FWD       = 3,
    parameter int NUM_REV       = 1,
    parameter int MIN_WIDTH_CYC = 200,
    parameter int FAILSAFE_CYC  = 3000,
    parameter int REFRESH_CYC   = FAILSAFE_CYC / 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_a,
    input  logic               pwr_b,
    input  logic               en_a,
    input  logic               en_b,
    input  logic [NUM_FWD-1:0] fwd_in,
    input  logic [NUM_REV-1:0] rev_in,
    output logic [NUM_FWD-1:0] fwd_out,
    output logic [NUM_FWD-1:0] fwd_oe,
    output logic [NUM_REV-1:0] rev_out,
    output logic [NUM_REV-1:0] rev_oe
);

    for (genvar g = 0; g < NUM_FWD; g++) begin : g_fwd
        iso_lane #(
            .MIN_WIDTH_CYC(MIN_WIDTH_CYC),
            .REFRESH_CYC(REFRESH_CYC),
            .FAILSAFE_CYC(FAILSAFE_CYC)
        ) u_lane (
            .clk(clk), .rst_n(rst_n), .src_pwr(pwr_a), .din(fwd_in[g]),
            .en(en_b), .dout(fwd_out[g]), .doe(fwd_oe[g])
        );
    end

    for (genvar g = 0; g < NUM_REV; g++) begin : g_rev
        iso_lane #(
            .MIN_WIDTH_CYC(MIN_WIDTH_CYC),
            .REFRESH_CYC(REFRESH_CYC),
            .FAILSAFE_CYC(FAILSAFE_CYC)
        ) u_lane (
            .clk(clk), .rst_n(rst_n), .src_pwr(pwr_b), .din(rev_in[g]),
            .en(en_a), .dout(rev_out[g]), .doe(rev_oe[g])
        );
    end

endmodule

// File: tb/test_iso_quad_link.sv
`timescale 1ns/1ps
module test_iso_quad_link;
    localparam int MINW = 20;
    localparam int REFR = 75;
    localparam int FS   = 300;
    localparam int SETTLE = MINW + 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_a = 1'b1, pwr_b = 1'b1, en_a = 1'b1, en_b = 1'b1;
    logic [2:0] fwd_in = 3'b000;
    logic [0:0] rev_in = 1'b0;
    logic [2:0] fwd_out, fwd_oe;
    logic [0:0] rev_out, rev_oe;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    iso_quad_link #(
        .NUM_FWD(3), .NUM_REV(1),
        .MIN_WIDTH_CYC(MINW), .FAILSAFE_CYC(FS), .REFRESH_CYC(REFR)
    ) i_iso_quad_link (
        .clk(clk), .rst_n(rst_n), .pwr_a(pwr_a), .pwr_b(pwr_b),
        .en_a(en_a), .en_b(en_b), .fwd_in(fwd_in), .rev_in(rev_in),
        .fwd_out(fwd_out), .fwd_oe(fwd_oe), .rev_out(rev_out), .rev_oe(rev_oe)
    );

    function automatic logic exp_out(logic pwr, logic lvl);
        return pwr ? lvl : 1'b1;
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_all(string req);
        for (int i = 0; i < 3; i++) begin
            chk(req, fwd_out[i], exp_out(pwr_a, fwd_in[i]));
            chk(req, fwd_oe[i], en_b);
        end
        chk(req, rev_out[0], exp_out(pwr_b, rev_in[0]));
        chk(req, rev_oe[0], en_a);
    endtask

    // pulse lane 0 to the opposite level for w cycles; report whether output moved
    task automatic glitch(int w, output logic moved);
        logic base;
        base = fwd_in[0];
        moved = 1'b0;
        fwd_in[0] = ~base;
        for (int k = 0; k < SETTLE + 30; k++) begin
            if (k == w) fwd_in[0] = base;
            @(negedge clk);
            if (fwd_out[0] !== base) moved = 1'b1;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic moved;
        void'($urandom(32'h1507));
        cyc(3);
        // R6: reset state, outputs high
        chk("R6 reset fwd0", fwd_out[0], 1'b1);
        chk("R6 reset rev0", rev_out[0], 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R6 after release", fwd_out[1], 1'b1);
        cyc(SETTLE);
        chk_all("R2 initial low");

        // R2 R7 R9: random levels and enables
        for (int it = 0; it < 30; it++) begin
            fwd_in = 3'($urandom);
            rev_in = 1'($urandom);
            en_a   = 1'($urandom);
            en_b   = 1'($urandom);
            @(negedge clk);
            chk("R7 oe same cycle", fwd_oe[0], en_b);
            chk("R7 oe same cycle", rev_oe[0], en_a);
            cyc(SETTLE);
            chk_all("R2 R9 random");
        end
        en_a = 1'b1; en_b = 1'b1;

        // R1: glitch rejection, both polarities
        fwd_in = 3'b000; cyc(SETTLE);
        glitch(MINW - 1, moved);
        chk("R1 high glitch min-1 rejected", moved, 1'b0);
        fwd_in = 3'b001; cyc(SETTLE);
        glitch(MINW - 1, moved);
        chk("R1 low glitch min-1 rejected", moved, 1'b0);
        for (int it = 0; it < 6; it++) begin
            glitch(1 + int'($urandom_range(MINW - 3)), moved);
            chk("R1 random glitch rejected", moved, 1'b0);
            fwd_in[0] = ~fwd_in[0]; cyc(SETTLE);
        end
        glitch(MINW, moved);
        chk("R1 min width accepted", moved, 1'b1);
        cyc(SETTLE);

        // R4: static input held long, refresh keeps it valid
        fwd_in = 3'b010; rev_in = 1'b0;
        for (int it = 0; it < 5; it++) begin
            cyc(2 * FS);
            chk_all("R4 static hold");
        end

        // R5 R8: side A loses power
        fwd_in = 3'b000; cyc(SETTLE);
        pwr_a = 1'b0;
        cyc(FS / 2);
        chk("R5 before timeout", fwd_out[0], 1'b0);
        chk("R5 before timeout", fwd_out[2], 1'b0);
        cyc(FS);
        chk_all("R5 R8 failsafe high");
        en_b = 1'b0;
        @(negedge clk);
        chk("R7 disabled during failsafe", fwd_oe[1], 1'b0);
        en_b = 1'b1;
        pwr_a = 1'b1;
        cyc(REFR + SETTLE);
        chk_all("R4 recovery by refresh");

        // R8: side B loses power, reverse lane only
        pwr_b = 1'b0;
        cyc(FS + REFR + 20);
        chk("R8 rev failsafe", rev_out[0], 1'b1);
        chk("R9 fwd unaffected", fwd_out[0], 1'b0);
        pwr_b = 1'b1;
        cyc(REFR + SETTLE);
        chk("R8 rev restored", rev_out[0], 1'b0);

        // R3: a decoded code is needed to go high after low
        rev_in = 1'b1; cyc(SETTLE);
        chk("R3 rev high code", rev_out[0], 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule